// File: doc/BRIEF.md
# PLL Divider Retune Sequencer

This block moves an external phase-locked loop to a new set of divider values without letting downstream logic see a glitching clock. On a start request it takes four divider values: input divide, output divide, feedback multiply and bandwidth divide. If the clock-source selector currently routes the PLL output, the block first parks the selector on the slow reference. It remembers the divider settings in force and holds the PLL in reset while it loads the new fields. It then releases reset and waits a settling time that grows with the input divider. After that it samples the lock indication for a bounded number of cycles.

If lock never arrives, the block rolls back once. It reloads the remembered settings through the same reset, load, settle and poll sequence, and it reports an error whether or not the old settings lock again. At the end it puts the selector back on the PLL output, but only when it had parked it. It then finishes with a one-cycle completion pulse. The PLL, its lock detector and the clock selector are outside the block. The selector's current value comes in on `mode_i`, and the block writes the selector with a strobe and a value.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `pll_rst_o` and `mode_set_o` are 0, and all four divider field outputs are 0, which encodes a divide value of 1.
- R2: Selector encodings are slow = 0, normal = 1 and deep = 2. When a start is taken while `mode_i` is 1, the block writes 0 to the selector in the first busy cycle, and the selector holds 0 for the whole time `pll_rst_o` is high. When `mode_i` is 0 or 2, the block makes no selector write at all.
- R3: The selector is written back to 1 only if R2 parked it. That write happens in the same cycle as `done_o` and after every lock wait has ended, so the selector ends on its original value.
- R4: After a sequence that locks, each divider field output equals its requested value minus one (a field value f means divide by f+1).
- R5: Divider field outputs change only while `pll_rst_o` is high, and `pll_rst_o` is high only while `busy_o` is high.
- R6: After reset is released, lock is ignored for CYC_PER_US × ((NR × 500) / 24 + 1) cycles, where NR is the input divide value being loaded. For a sequence that locks on the first sample, busy therefore lasts 4 + that count cycles.
- R7: When lock is not seen in POLL_MAX consecutive samples, the block sets `err_o` and reloads the settings that were in force before the start. It then settles and polls again, and the fields end on the old values.
- R8: A timeout during the rollback pass does not trigger a further retry. The sequence ends with `err_o` high and the old field values in place.
- R9: A start request seen while `busy_o` is high is ignored, and the values presented with it have no effect on the outcome.
- R10: `done_o` is high for exactly one cycle, in the same cycle that `busy_o` falls. `err_o` is valid with it and keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to apply the presented divider values |
| nr_i | input | NR_W | Requested input divide value (1 or more) |
| no_i | input | NO_W | Requested output divide value (1 or more) |
| nf_i | input | NF_W | Requested feedback multiply value (1 or more) |
| nb_i | input | NB_W | Requested bandwidth divide value (1 or more) |
| mode_i | input | 2 | Current clock-source selector value |
| lock_i | input | 1 | PLL lock indication |
| mode_set_o | output | 1 | Selector write strobe |
| mode_val_o | output | 2 | Value written to the selector |
| pll_rst_o | output | 1 | PLL reset |
| nr_fld_o | output | NR_W | Input divide field (value minus one) |
| no_fld_o | output | NO_W | Output divide field (value minus one) |
| nf_fld_o | output | NF_W | Feedback multiply field (value minus one) |
| nb_fld_o | output | NB_W | Bandwidth divide field (value minus one) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last sequence timed out on lock |

## Verification
The bench builds the block with CYC_PER_US = 2 and POLL_MAX = 16 and keeps the other widths at their defaults. Short polls make both the single-rollback path and the double-timeout path cheap enough to run many times. Two cycles per microsecond keep even the largest input divide (63, a settle of 2626 cycles) inside the run, while the exact busy length still shows any off-by-one error in the settle or poll counts. The lock model answers only for the new or only for the old field values, so each of the three outcomes can be forced on purpose.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam logic [1:0] MODE_SLOW   = 2'd0;
    localparam logic [1:0] MODE_NORMAL = 2'd1;
    localparam logic [1:0] MODE_DEEP   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_WRITE,
        ST_RST_OFF,
        ST_SETTLE,
        ST_POLL
    } seq_state_e;

endpackage

// File: rtl/pll_seq_settle.sv
// Settling time in clock cycles for a given input divide value.
module pll_seq_settle #(
    parameter int NR_W       = 6,
    parameter int CYC_PER_US = 24,
    parameter int CNT_W      = 32
) (
    input  logic [NR_W-1:0]  nr_i,
    output logic [CNT_W-1:0] cycles_o
);
    localparam int PW = NR_W + 10;

    logic [PW-1:0] usec;

    always_comb begin
        usec     = (PW'(nr_i) * PW'(500)) / PW'(24) + PW'(1);
        cycles_o = CNT_W'(usec) * CNT_W'(CYC_PER_US);
    end
endmodule

// File: rtl/pll_seq_downcnt.sv
// Shared down-counter for the settle wait and the lock poll window.
module pll_seq_downcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int NR_W       = 6,
    parameter int NO_W       = 4,
    parameter int NF_W       = 13,
    parameter int NB_W       = 12,
    parameter int CYC_PER_US = 24,
    parameter int POLL_MAX   = 24000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NR_W-1:0] nr_i,
    input  logic [NO_W-1:0] no_i,
    input  logic [NF_W-1:0] nf_i,
    input  logic [NB_W-1:0] nb_i,
    input  logic [1:0]      mode_i,
    input  logic            lock_i,
    output logic            mode_set_o,
    output logic [1:0]      mode_val_o,
    output logic            pll_rst_o,
    output logic [NR_W-1:0] nr_fld_o,
    output logic [NO_W-1:0] no_fld_o,
    output logic [NF_W-1:0] nf_fld_o,
    output logic [NB_W-1:0] nb_fld_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o
);
    localparam int DLY_W  = NR_W + 10 + $clog2(CYC_PER_US + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam int CNT_W  = (DLY_W > POLL_W) ? DLY_W : POLL_W;

    typedef struct packed {
        seq_state_e      state;
        logic            busy;
        logic            done;
        logic            err;
        logic            rst;
        logic            mset;
        logic [1:0]      mval;
        logic            remux;
        logic            retry;
        logic [NR_W-1:0] tgt_nr;
        logic [NO_W-1:0] tgt_no;
        logic [NF_W-1:0] tgt_nf;
        logic [NB_W-1:0] tgt_nb;
        logic [NR_W-1:0] sv_nr;
        logic [NO_W-1:0] sv_no;
        logic [NF_W-1:0] sv_nf;
        logic [NB_W-1:0] sv_nb;
        logic [NR_W-1:0] f_nr;
        logic [NO_W-1:0] f_no;
        logic [NF_W-1:0] f_nf;
        logic [NB_W-1:0] f_nb;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] settle_cyc;

    pll_seq_settle #(
        .NR_W(NR_W), .CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)
    ) u_settle (
        .nr_i(r_q.tgt_nr), .cycles_o(settle_cyc)
    );

    pll_seq_downcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .val_i(cnt_val),
        .dec_i(cnt_dec), .zero_o(cnt_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.mset = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_RST_ON;
                    r_d.busy   = 1'b1;
                    r_d.err    = 1'b0;
                    r_d.retry  = 1'b0;
                    r_d.tgt_nr = nr_i;
                    r_d.tgt_no = no_i;
                    r_d.tgt_nf = nf_i;
                    r_d.tgt_nb = nb_i;
                    r_d.sv_nr  = r_q.f_nr + NR_W'(1);
                    r_d.sv_no  = r_q.f_no + NO_W'(1);
                    r_d.sv_nf  = r_q.f_nf + NF_W'(1);
                    r_d.sv_nb  = r_q.f_nb + NB_W'(1);
                    r_d.remux  = (mode_i == MODE_NORMAL);
                    if (mode_i == MODE_NORMAL) begin
                        r_d.mset = 1'b1;
                        r_d.mval = MODE_SLOW;
                    end
                end
            end
            ST_RST_ON: begin
                r_d.rst   = 1'b1;
                r_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.f_nr  = r_q.tgt_nr - NR_W'(1);
                r_d.f_no  = r_q.tgt_no - NO_W'(1);
                r_d.f_nf  = r_q.tgt_nf - NF_W'(1);
                r_d.f_nb  = r_q.tgt_nb - NB_W'(1);
                r_d.state = ST_RST_OFF;
            end
            ST_RST_OFF: begin
                r_d.rst   = 1'b0;
                cnt_load  = 1'b1;
                cnt_val   = settle_cyc - CNT_W'(1);
                r_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt_zero) begin
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(POLL_MAX - 1);
                    r_d.state = ST_POLL;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_POLL: begin
                if (lock_i || (cnt_zero && r_q.retry)) begin
                    if (!lock_i) r_d.err = 1'b1;
                    r_d.state = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                    if (r_q.remux) begin
                        r_d.mset = 1'b1;
                        r_d.mval = MODE_NORMAL;
                    end
                end else if (cnt_zero) begin
                    r_d.err    = 1'b1;
                    r_d.retry  = 1'b1;
                    r_d.tgt_nr = r_q.sv_nr;
                    r_d.tgt_no = r_q.sv_no;
                    r_d.tgt_nf = r_q.sv_nf;
                    r_d.tgt_nb = r_q.sv_nb;
                    r_d.state  = ST_RST_ON;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_set_o = r_q.mset;
    assign mode_val_o = r_q.mval;
    assign pll_rst_o  = r_q.rst;
    assign nr_fld_o   = r_q.f_nr;
    assign no_fld_o   = r_q.f_no;
    assign nf_fld_o   = r_q.f_nf;
    assign nb_fld_o   = r_q.f_nb;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
    parameter int FW = 35
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_set_o,
    input logic [1:0]    mode_val_o,
    input logic          pll_rst_o,
    input logic [FW-1:0] fields,
    input logic          busy_o,
    input logic          done_o
);
    assert_park_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set_o && mode_val_o == 2'd0) |-> $rose(busy_o));

    assert_restore_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set_o && mode_val_o == 2'd1) |-> done_o);

    assert_fields_under_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fields) |-> pll_rst_o);

    assert_reset_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> busy_o);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind pll_retune_seq pll_seq_chk #(.FW(NR_W + NO_W + NF_W + NB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_set_o(mode_set_o), .mode_val_o(mode_val_o),
    .pll_rst_o(pll_rst_o), .fields({nr_fld_o, no_fld_o, nf_fld_o, nb_fld_o}),
    .busy_o(busy_o), .done_o(done_o)
);

// File: tb/pll_retune_seq_test.sv
`timescale 1ns/1ps
module pll_retune_seq_test;
    localparam int CYC  = 2;
    localparam int PMAX = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [5:0] nr_i = '0;
    logic [3:0] no_i = '0;
    logic [12:0] nf_i = '0;
    logic [11:0] nb_i = '0;
    logic [1:0] mode_reg = 2'd0;
    logic lock_i;
    logic mode_set_o, pll_rst_o, busy_o, done_o, err_o;
    logic [1:0] mode_val_o;
    logic [5:0] nr_fld_o;
    logic [3:0] no_fld_o;
    logic [12:0] nf_fld_o;
    logic [11:0] nb_fld_o;

    logic mreq = 1'b0;
    logic [1:0] mreq_val = 2'd0;
    logic ok_new = 1'b0, ok_old = 1'b0;
    logic [5:0] new_nr = 6'd1;

    int checks = 0, fails = 0;
    int cur_nr = 1, cur_no = 1, cur_nf = 1, cur_nb = 1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pll_retune_seq #(.CYC_PER_US(CYC), .POLL_MAX(PMAX)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .nr_i(nr_i), .no_i(no_i),
        .nf_i(nf_i), .nb_i(nb_i), .mode_i(mode_reg), .lock_i(lock_i),
        .mode_set_o(mode_set_o), .mode_val_o(mode_val_o), .pll_rst_o(pll_rst_o),
        .nr_fld_o(nr_fld_o), .no_fld_o(no_fld_o), .nf_fld_o(nf_fld_o),
        .nb_fld_o(nb_fld_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    // PLL model: locks out of reset only for the chosen field set
    assign lock_i = !pll_rst_o && ((nr_fld_o == new_nr - 6'd1) ? ok_new : ok_old);

    // Clock selector model
    always @(posedge clk) begin
        if (mreq) mode_reg <= mreq_val;
        else if (mode_set_o) mode_reg <= mode_val_o;
    end

    function automatic int settle(input int nr);
        return CYC * ((nr * 500) / 24 + 1);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int nr, input int no, input int nf, input int nb,
                       input logic [1:0] md, input int sc, input bit inject);
        int o_nr, o_no, o_nf, o_nb, bcnt, mw, guard, exp_busy, park_bad, bad_val;
        o_nr = cur_nr; o_no = cur_no; o_nf = cur_nf; o_nb = cur_nb;
        mreq = 1'b1; mreq_val = md;
        @(negedge clk);
        mreq = 1'b0;
        new_nr = 6'(nr);
        ok_new = (sc == 0);
        ok_old = (sc == 1);
        nr_i = 6'(nr); no_i = 4'(no); nf_i = 13'(nf); nb_i = 12'(nb);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        bcnt = 0; mw = 0; guard = 0; park_bad = 0; bad_val = 0;
        while (!done_o && guard < 30000) begin
            if (mode_set_o) begin
                mw++;
                if (mode_val_o != 2'd0) bad_val++;
            end
            if (pll_rst_o && md == 2'd1 && mode_reg != 2'd0) park_bad++;
            if (busy_o) bcnt++;
            if (inject && bcnt == 5) begin
                start_i = 1'b1;
                nr_i = ~nr_i; nf_i = ~nf_i;
            end else begin
                start_i = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (guard >= 30000) begin
            checks++; fails++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", guard, 0);
        end
        if (mode_set_o) begin
            mw++;
            chk("R3 restore value", mode_val_o, 1);
        end
        if (sc == 0) exp_busy = 4 + settle(nr);
        else exp_busy = 3 + settle(nr) + PMAX + 3 + settle(o_nr) + ((sc == 1) ? 1 : PMAX);
        if (sc == 0) begin
            cur_nr = nr; cur_no = no; cur_nf = nf; cur_nb = nb;
        end
        chk(sc == 0 ? "R6 busy length" : (sc == 1 ? "R7 busy length" : "R8 busy length"),
            bcnt, exp_busy);
        chk(inject ? "R9 err after ignored start" : "R10 err", err_o, sc != 0);
        chk(sc == 0 ? "R4 nr field" : "R7 nr field", nr_fld_o, cur_nr - 1);
        chk(sc == 0 ? "R4 no field" : "R7 no field", no_fld_o, cur_no - 1);
        chk(inject ? "R9 nf field" : "R4 nf field", nf_fld_o, cur_nf - 1);
        chk(sc == 2 ? "R8 nb field" : "R4 nb field", nb_fld_o, cur_nb - 1);
        chk("R2 selector write count", mw, (md == 2'd1) ? 2 : 0);
        chk("R2 park value", bad_val, 0);
        chk("R2 parked during reset", park_bad, 0);
        @(negedge clk);
        chk("R10 done one cycle", done_o, 0);
        chk("R10 err held", err_o, sc != 0);
        chk("R3 selector restored", mode_reg, md);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 reset", pll_rst_o, 0);
        chk("R1 mode strobe", mode_set_o, 0);
        chk("R1 fields", {nr_fld_o, no_fld_o, nf_fld_o, nb_fld_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", busy_o, 0);

        // directed corners
        run(3, 2, 100, 7, 2'd1, 0, 0);
        run(5, 4, 200, 9, 2'd0, 1, 0);
        run(6, 3, 50, 2, 2'd1, 2, 0);
        run(63, 15, 8191, 4095, 2'd2, 0, 0);
        run(2, 1, 1, 1, 2'd1, 1, 1);
        run(4, 5, 77, 33, 2'd1, 0, 1);

        for (int i = 0; i < 28; i++) begin
            int nr;
            do nr = 1 + int'($urandom % 8); while (nr == cur_nr);
            run(nr, 1 + int'($urandom % 15), 1 + int'($urandom % 8191),
                1 + int'($urandom % 4095), 2'($urandom % 3),
                int'($urandom % 3), bit'($urandom % 3 == 0));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 190000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule